// File: doc/BRIEF.md
# Floating-Point Input Gain Mapper

This block takes a sample word from a 16-bit converter pin bus that carries a block-floating value (a signed mantissa plus a small exponent) and turns it into a plain fixed-point two's-complement sample. The exponent picks a binary shift of the mantissa. Each exponent step is one binary position, which is a 6 dB gain step. Downstream filtering then sees one linear number scale whatever gain setting the front end used.

The bus can be packed in one of two ways, chosen by a format select input. In the narrow-mantissa format, the upper fifteen pins carry the mantissa and a 2-bit exponent gives four gain steps, spanning 18 dB. In the full-mantissa format, all sixteen pins carry the mantissa and one exponent bit gives two steps, spanning 6 dB. Exponent code zero gives the largest shift. The output is three bits wider than the bus, so the largest shift cannot overflow. The result is registered, and a valid flag follows the input strobe one clock later.

Top module: `fp_gain_mapper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `out_valid` and `out_sample` to zero.
- R2: `out_valid` goes high in the cycle after a rising edge with `in_valid` high, and low in the cycle after a rising edge with `in_valid` low. The latency is one clock.
- R3: When `fmt_sel` = 0 (narrow-mantissa format), `pin_bus[15:1]` is the mantissa and `pin_bus[0]` has no effect. The internal 16-bit word is `{pin_bus[15:1], 1'b0}`.
- R4: In narrow-mantissa format, `exp_code` values 0, 1, 2 and 3 multiply the internal word by 8, 4, 2 and 1. These are gains of 18, 12, 6 and 0 dB.
- R5: When `fmt_sel` = 1 (full-mantissa format), all of `pin_bus[15:0]` is the mantissa. `exp_code[0]` = 0 multiplies it by 2 and `exp_code[0]` = 1 multiplies it by 1. `exp_code[1]` has no effect.
- R6: The mantissa is two's complement. `out_sample` is the 19-bit sign-extended, shifted value and never overflows: for example 0x8000 with a ×8 gain gives 19'h40000.
- R7: While `in_valid` is low, `out_sample` keeps its last value.
- R8: The format and exponent are sampled together with each valid sample. A change of `fmt_sel` between two back-to-back samples affects only the later sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pin bus and exponent hold a sample this cycle |
| pin_bus | input | 16 | Raw converter pin bus |
| exp_code | input | 2 | Exponent bits attached to the sample |
| fmt_sel | input | 1 | Packing format: 0 narrow mantissa, 1 full mantissa |
| out_valid | output | 1 | `out_sample` holds a new sample |
| out_sample | output | 19 | Sign-extended fixed-point sample |

## Verification
The only internal state is the registered sample and its valid flag, so any fault shows at the ports one clock after the sample that caused it. A wrong shift decode gives an output off by a power of two for one exponent code or one format only. The tests therefore sweep every code in both formats, with positive, negative and full-scale mantissas. A bad sign extension corrupts the top three output bits of negative samples. A faulty hold path changes the output during idle cycles. A format select that is registered on the wrong cycle shows up as a wrongly scaled sample right after a format change in a back-to-back stream.

// File: rtl/fgm_pkg.sv
// Package: shared types for the floating-point input gain mapper.
// Assumes nothing beyond a two-value packing format select.
package fgm_pkg;

    // Packing format of the pin bus.
    typedef enum logic {
        FMT_NARROW = 1'b0,   // mantissa on the upper bits, full exponent
        FMT_FULL   = 1'b1    // mantissa on every bit, exponent minus its top bit
    } fmt_e;

endpackage

// File: rtl/fgm_unpack.sv
// Module: fgm_unpack
// Forms the internal mantissa word and the left-shift amount from the raw
// pin bus, the exponent code and the packing format. Exponent code zero
// maps to the largest shift. Assumes EXP_W >= 2 so the full format keeps
// at least one exponent bit.
module fgm_unpack
    import fgm_pkg::*;
#(
    parameter int PIN_W = 16,
    parameter int EXP_W = 2,
    parameter int SH_W  = EXP_W
) (
    input  logic [PIN_W-1:0] pin_bus,
    input  logic [EXP_W-1:0] exp_code,
    input  fmt_e             fmt,
    output logic [PIN_W-1:0] word,
    output logic [SH_W-1:0]  shamt
);

    localparam int MAX_SH_NARROW = (1 << EXP_W) - 1;
    localparam int MAX_SH_FULL   = (1 << (EXP_W - 1)) - 1;

    // Select mantissa placement and shift amount for the active format.
    always_comb begin
        if (fmt == FMT_NARROW) begin
            word  = {pin_bus[PIN_W-1:1], 1'b0};
            shamt = SH_W'(MAX_SH_NARROW) - SH_W'(exp_code);
        end else begin
            word  = pin_bus;
            shamt = SH_W'(MAX_SH_FULL) - SH_W'(exp_code[EXP_W-2:0]);
        end
    end

endmodule

// File: rtl/fgm_shifter.sv
// Module: fgm_shifter
// Sign-extends a two's-complement word to the output width and shifts it
// left by a binary-weighted amount, one stage per shift bit. Assumes
// OUT_W - IN_W covers the largest shift so no bit is lost.
module fgm_shifter #(
    parameter int IN_W  = 16,
    parameter int SH_W  = 2,
    parameter int OUT_W = 19
) (
    input  logic [IN_W-1:0]  din,
    input  logic [SH_W-1:0]  shamt,
    output logic [OUT_W-1:0] dout
);

    localparam int EXT_W = OUT_W - IN_W;

    logic [OUT_W-1:0] stage [SH_W+1];

    // Sign extension feeding the first stage.
    assign stage[0] = {{EXT_W{din[IN_W-1]}}, din};

    genvar gi;
    generate
        for (gi = 0; gi < SH_W; gi++) begin : g_stage
            // Stage gi shifts by 2**gi when its shift bit is set.
            assign stage[gi+1] = shamt[gi] ? (stage[gi] << (1 << gi)) : stage[gi];
        end
    endgenerate

    assign dout = stage[SH_W];

endmodule

// File: rtl/fgm_outreg.sv
// Module: fgm_outreg
// Output register for the mapped sample and its valid flag. It loads the
// sample only on valid input cycles and holds it otherwise. Synchronous
// active-low reset.
module fgm_outreg #(
    parameter int OUT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OUT_W-1:0] din,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sample
);

    // Valid flag follows the input strobe one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Sample register loads on valid cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_sample <= '0;
        else if (in_valid) out_sample <= din;
    end

endmodule

// File: rtl/fp_gain_mapper.sv
// Module: fp_gain_mapper (top)
// Maps a block-floating pin bus sample to a sign-extended fixed-point
// sample, one binary position per exponent step, registered with one
// cycle of latency. Assumes the format select and exponent are valid
// together with the pin bus when in_valid is high.
module fp_gain_mapper #(
    parameter int PIN_W = 16,
    parameter int EXP_W = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [PIN_W-1:0]                    pin_bus,
    input  logic [EXP_W-1:0]                    exp_code,
    input  logic                                fmt_sel,
    output logic                                out_valid,
    output logic [PIN_W+(1<<EXP_W)-2:0]         out_sample
);

    import fgm_pkg::*;

    localparam int SH_W  = EXP_W;
    localparam int OUT_W = PIN_W + (1 << EXP_W) - 1;

    fmt_e             fmt;
    logic [PIN_W-1:0] word;
    logic [SH_W-1:0]  shamt;
    logic [OUT_W-1:0] mapped;

    // Interpret the raw select bit as a packing format.
    assign fmt = fmt_e'(fmt_sel);

    fgm_unpack #(
        .PIN_W (PIN_W),
        .EXP_W (EXP_W),
        .SH_W  (SH_W)
    ) u_unpack (
        .pin_bus  (pin_bus),
        .exp_code (exp_code),
        .fmt      (fmt),
        .word     (word),
        .shamt    (shamt)
    );

    fgm_shifter #(
        .IN_W  (PIN_W),
        .SH_W  (SH_W),
        .OUT_W (OUT_W)
    ) u_shift (
        .din   (word),
        .shamt (shamt),
        .dout  (mapped)
    );

    fgm_outreg #(
        .OUT_W (OUT_W)
    ) u_oreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .din        (mapped),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

endmodule

// File: rtl/fp_gain_mapper_chk.sv
// Module: fp_gain_mapper_chk
// Assertion checker bound to fp_gain_mapper. Observes ports only.
module fp_gain_mapper_chk #(
    parameter int PIN_W = 16,
    parameter int EXP_W = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic [PIN_W-1:0]            pin_bus,
    input logic [EXP_W-1:0]            exp_code,
    input logic                        fmt_sel,
    input logic                        out_valid,
    input logic [PIN_W+(1<<EXP_W)-2:0] out_sample
);

    localparam int OUT_W  = PIN_W + (1 << EXP_W) - 1;
    localparam int MAX_SH = (1 << EXP_W) - 1;

    // Mask of bits that must be zero for a narrow-format sample with code e.
    function automatic logic [OUT_W-1:0] low_mask(input logic [EXP_W-1:0] e);
        low_mask = (OUT_W'(1) << (MAX_SH + 1 - int'(e))) - OUT_W'(1);
    endfunction

    // R2: a valid input produces a valid output one clock later.
    a_r2_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: an idle input cycle gives an idle output cycle.
    a_r2_valid_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: the sample holds through idle cycles.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));

    // R6: the output sign equals the mantissa sign.
    a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_sample[OUT_W-1] == $past(pin_bus[PIN_W-1]));

    // R3: narrow format leaves the dropped pin and shifted-in bits at zero.
    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_sel) |=> (out_sample & low_mask($past(exp_code))) == '0);

    // R5: full format with unity code passes the bus through sign-extended.
    a_r5_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_sel && exp_code[0]) |=>
        out_sample == {{(OUT_W-PIN_W){$past(pin_bus[PIN_W-1])}}, $past(pin_bus)});

endmodule

bind fp_gain_mapper fp_gain_mapper_chk #(
    .PIN_W (PIN_W),
    .EXP_W (EXP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .pin_bus    (pin_bus),
    .exp_code   (exp_code),
    .fmt_sel    (fmt_sel),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/fp_gain_mapper_bench.sv
// Directed bench for fp_gain_mapper: one task per scenario.
module fp_gain_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] pin_bus = '0;
    logic [1:0]  exp_code = '0;
    logic        fmt_sel = 1'b0;
    logic        out_valid;
    logic [18:0] out_sample;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    fp_gain_mapper u_fp_gain_mapper (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .pin_bus    (pin_bus),
        .exp_code   (exp_code),
        .fmt_sel    (fmt_sel),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #10 clk = ~clk;

    // Expected output from the requirement text (R3, R4, R5, R6).
    function automatic logic [18:0] ref_map(input logic [15:0] p, input logic [1:0] e,
                                            input logic f);
        logic [15:0] w;
        int          sh;
        logic [18:0] x;
        if (!f) begin
            w  = {p[15:1], 1'b0};
            sh = 3 - int'(e);
        end else begin
            w  = p;
            sh = e[0] ? 0 : 1;
        end
        x = {{3{w[15]}}, w};
        ref_map = x << sh;
    endfunction

    task automatic check(input string tag, input logic [18:0] got, input logic [18:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Present one sample, then check it at the following falling edge.
    task automatic send_one(input string tag, input logic [15:0] p, input logic [1:0] e,
                            input logic f);
        @(negedge clk);
        pin_bus = p; exp_code = e; fmt_sel = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {18'd0, out_valid}, 19'd1);
        check(tag, out_sample, ref_map(p, e, f));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 out_valid at reset", {18'd0, out_valid}, 19'd0);
        check("R1 out_sample at reset", out_sample, 19'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle after reset", {18'd0, out_valid}, 19'd0);
    endtask

    task automatic t_narrow_sweep();
        for (int e = 0; e < 4; e++) begin
            send_one("R4 narrow positive", 16'h1234, 2'(e), 1'b0);
            send_one("R4 narrow negative", 16'hC0DE, 2'(e), 1'b0);
        end
    endtask

    task automatic t_lsb_ignored();
        send_one("R3 pin0 set", 16'h0003, 2'd3, 1'b0);
        check("R3 pin0 dropped value", out_sample, 19'h00002);
        send_one("R3 pin0 clear", 16'h0002, 2'd3, 1'b0);
        check("R3 pin0 clear value", out_sample, 19'h00002);
    endtask

    task automatic t_full_sweep();
        for (int e = 0; e < 4; e++) begin
            send_one("R5 full positive", 16'h2345, 2'(e), 1'b1);
            send_one("R5 full negative", 16'hFFFF, 2'(e), 1'b1);
        end
        send_one("R5 exp1 ignored a", 16'h0101, 2'b00, 1'b1);
        check("R5 exp1 ignored a value", out_sample, 19'h00202);
        send_one("R5 exp1 ignored b", 16'h0101, 2'b10, 1'b1);
        check("R5 exp1 ignored b value", out_sample, 19'h00202);
    endtask

    task automatic t_extremes();
        send_one("R6 most negative x8", 16'h8000, 2'd0, 1'b0);
        check("R6 most negative x8 value", out_sample, 19'h40000);
        send_one("R6 most positive x8", 16'h7FFF, 2'd0, 1'b0);
        check("R6 most positive x8 value", out_sample, 19'h3FFF0);
        send_one("R6 most negative x2 full", 16'h8000, 2'd0, 1'b1);
        check("R6 most negative x2 value", out_sample, 19'h70000);
    endtask

    task automatic t_hold();
        logic [18:0] last;
        send_one("R7 load", 16'h5A5A, 2'd1, 1'b0);
        last = out_sample;
        pin_bus = 16'hFFFF; exp_code = 2'd0; fmt_sel = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 held while idle", out_sample, last);
            check("R2 valid low while idle", {18'd0, out_valid}, 19'd0);
        end
    endtask

    task automatic t_stream();
        logic [15:0] p_q;
        logic [1:0]  e_q;
        logic        f_q;
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            p_q = 16'(16'h9E37 * (i + 1));
            e_q = 2'(i);
            f_q = i[1];
            pin_bus = p_q; exp_code = e_q; fmt_sel = f_q; in_valid = 1'b1;
            @(negedge clk);
            check("R8 stream valid", {18'd0, out_valid}, 19'd1);
            check("R8 stream sample after format change", out_sample, ref_map(p_q, e_q, f_q));
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_narrow_sweep();
        t_lsb_ignored();
        t_full_sweep();
        t_extremes();
        t_hold();
        t_stream();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule